// File: doc/BRIEF.md
# Host Bus Register Access Decoder

This block sits between a host processor bus and the register file of a serial communication peripheral. It gives no storage of its own to the data bus. It decides whether the current bus cycle is addressed to this device, which of the eight registers is involved, and whether the cycle is a read or a write. It then produces per-register select lines, an enable for the tri-state data pads and a drive-disable line for external bus transceivers.

The device is selected by three chip-select inputs of mixed polarity that must all agree. Each direction accepts two strobes, one active high and one active low, and the unused one is tied inactive. For hosts that multiplex address and data, an address strobe freezes the chip selects and register address. The block samples everything in a system clock domain. Reads are decoded combinationally, so the pads are released as soon as the read strobe drops. A write becomes a single-cycle registered pulse taken on the leading edge of the strobe.

Top module: `host_bus_decoder`

## Requirements
- R1: The device counts as selected only when `cs0`=1, `cs1`=1 and `cs2_n`=0 hold together. In any other combination, `rd_sel` and `wr_sel` stay all zero, `data_oe` stays 0 and `ddis_n` stays 1.
- R2: Select outputs are one-hot and index the register address. Register address k (0..7, `addr[0]` being the least significant bit) drives bit k of `rd_sel` or `wr_sel`, and at most one bit of each is ever set.
- R3: While `as_n` is 0, the address path is transparent. `addr_o` follows `addr`, and the live chip selects take effect in the same cycle.
- R4: While `as_n` is 1, the decoder uses the address and chip-select state sampled on the last clock edge at which `as_n` was 0. Changes on `addr`, `cs0`, `cs1` or `cs2_n` are then ignored.
- R5: A read is active when `ior`=1 or `ior_n`=0. During a selected read, `rd_sel` and `data_oe` are set without a clock edge, and both clear as soon as the read strobes go inactive.
- R6: `ddis_n` is 0 exactly while a selected read is active and 1 otherwise.
- R7: A write is active when `iow`=1 or `iow_n`=0. At the first rising clock edge where a selected write is seen after an edge where it was not, `wr_sel` is set for exactly one clock cycle, however long the strobe is held.
- R8: A read takes priority over a write. A write strobe that begins while a read is active produces no `wr_sel` pulse, even after the read ends while the write strobe is still held.
- R9: While `rst` is 1, `rd_sel` and `wr_sel` are 0, `data_oe` is 0, `ddis_n` is 1 and `addr_o` is 0, whatever the bus inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset, asynchronous assert |
| as_n | input | 1 | Address strobe; 0 = transparent, 1 = hold |
| cs0 | input | 1 | Chip select, active high |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| addr | input | ADDR_W | Register address |
| ior | input | 1 | Read strobe, active high |
| ior_n | input | 1 | Read strobe, active low |
| iow | input | 1 | Write strobe, active high |
| iow_n | input | 1 | Write strobe, active low |
| addr_o | output | ADDR_W | Effective (held or live) register address |
| rd_sel | output | 2**ADDR_W | One-hot register read select |
| wr_sel | output | 2**ADDR_W | One-hot single-cycle register write pulse |
| data_oe | output | 1 | Data pad output enable |
| ddis_n | output | 1 | Transceiver drive disable, low during selected read |

## Verification
A read and a write can arrive in the same cycle. The bench forces this by raising `ior` and `iow` on the same falling clock edge. It then checks that `rd_sel` shows the addressed register and that `wr_sel` stays zero on the following edges. It then drops the read while keeping the write strobe high. No late write pulse may appear, because the write's leading edge fell inside the read.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
    parameter int DEF_ADDR_W = 3;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;
endpackage

// File: rtl/hbd_addr_hold.sv
module hbd_addr_hold #(
    parameter int ADDR_W = hbd_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_n,
    input  logic              cs_live,
    input  logic [ADDR_W-1:0] addr_live,
    output logic              cs_eff,
    output logic [ADDR_W-1:0] addr_eff
);
    typedef struct packed {
        logic              cs;
        logic [ADDR_W-1:0] addr;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (!as_n) begin
            hold_d.cs   = cs_live;
            hold_d.addr = addr_live;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) hold_q <= '0;
        else     hold_q <= hold_d;
    end

    assign cs_eff   = as_n ? hold_q.cs   : cs_live;
    assign addr_eff = as_n ? hold_q.addr : addr_live;

    // R4
    hold_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        $past(as_n) |-> $stable(hold_q));
endmodule

// File: rtl/hbd_strobe.sv
module hbd_strobe (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          ior,
    input  logic          ior_n,
    input  logic          iow,
    input  logic          iow_n,
    output hbd_pkg::acc_e acc,
    output logic          wr_lead
);
    import hbd_pkg::*;

    typedef struct packed {
        logic wr_prev;
    } stb_t;

    stb_t stb_d, stb_q;
    logic rd_raw, wr_raw;

    assign rd_raw = ior | ~ior_n;
    assign wr_raw = iow | ~iow_n;

    always_comb begin
        stb_d.wr_prev = sel & wr_raw;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) stb_q <= '0;
        else     stb_q <= stb_d;
    end

    always_comb begin
        acc = ACC_IDLE;
        if (!rst && sel) begin
            if (rd_raw)      acc = ACC_READ;
            else if (wr_raw) acc = ACC_WRITE;
        end
    end

    assign wr_lead = ~rst & sel & wr_raw & ~stb_q.wr_prev & ~rd_raw;
endmodule

// File: rtl/host_bus_decoder.sv
module host_bus_decoder #(
    parameter  int ADDR_W = hbd_pkg::DEF_ADDR_W,
    localparam int NREG   = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_n,
    input  logic              cs0,
    input  logic              cs1,
    input  logic              cs2_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ior,
    input  logic              ior_n,
    input  logic              iow,
    input  logic              iow_n,
    output logic [ADDR_W-1:0] addr_o,
    output logic [NREG-1:0]   rd_sel,
    output logic [NREG-1:0]   wr_sel,
    output logic              data_oe,
    output logic              ddis_n
);
    import hbd_pkg::*;

    logic              cs_live, cs_eff, wr_lead;
    logic [ADDR_W-1:0] addr_eff;
    acc_e              acc;
    logic [NREG-1:0]   rd_dec, wr_dec;

    typedef struct packed {
        logic [NREG-1:0] wr_sel;
    } top_t;

    top_t top_d, top_q;

    assign cs_live = cs0 & cs1 & ~cs2_n;

    hbd_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .as_n     (as_n),
        .cs_live  (cs_live),
        .addr_live(addr),
        .cs_eff   (cs_eff),
        .addr_eff (addr_eff)
    );

    hbd_strobe u_stb (
        .clk    (clk),
        .rst    (rst),
        .sel    (cs_eff),
        .ior    (ior),
        .ior_n  (ior_n),
        .iow    (iow),
        .iow_n  (iow_n),
        .acc    (acc),
        .wr_lead(wr_lead)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign rd_dec[g] = (acc == ACC_READ) && (addr_eff == ADDR_W'(g));
        assign wr_dec[g] = wr_lead && (addr_eff == ADDR_W'(g));
    end

    always_comb begin
        top_d.wr_sel = wr_dec;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) top_q <= '0;
        else     top_q <= top_d;
    end

    assign rd_sel  = rd_dec;
    assign wr_sel  = top_q.wr_sel;
    assign data_oe = (acc == ACC_READ);
    assign ddis_n  = ~data_oe;
    assign addr_o  = rst ? '0 : addr_eff;

    // R2
    rd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_sel));
    // R2
    wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_sel));
    // R7
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        (|wr_sel) |=> (wr_sel == '0));
    // R8
    wr_not_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        (|wr_sel) |-> $past(acc != ACC_READ));
    // R6
    ddis_read_chk: assert property (@(posedge clk) disable iff (rst)
        (|rd_sel) |-> !ddis_n);
endmodule

// File: tb/sim_host_bus_decoder.sv
module sim_host_bus_decoder;
    localparam int AW = 3;
    localparam int NR = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic as_n = 1'b0, cs0 = 1'b1, cs1 = 1'b1, cs2_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic ior = 1'b0, ior_n = 1'b1, iow = 1'b0, iow_n = 1'b1;
    logic [AW-1:0] addr_o;
    logic [NR-1:0] rd_sel, wr_sel;
    logic data_oe, ddis_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    host_bus_decoder #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .as_n(as_n), .cs0(cs0), .cs1(cs1), .cs2_n(cs2_n),
        .addr(addr), .ior(ior), .ior_n(ior_n), .iow(iow), .iow_n(iow_n),
        .addr_o(addr_o), .rd_sel(rd_sel), .wr_sel(wr_sel),
        .data_oe(data_oe), .ddis_n(ddis_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        @(negedge clk);
        ior = 0; ior_n = 1; iow = 0; iow_n = 1;
        as_n = 0; cs0 = 1; cs1 = 1; cs2_n = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        addr = 3'd4; ior = 1;
        #1;
        chk("R9 rd_sel", rd_sel, 0);
        chk("R9 data_oe", data_oe, 0);
        chk("R9 ddis_n", ddis_n, 1);
        chk("R9 addr_o", addr_o, 0);
        iow = 1;
        @(posedge clk); #1;
        chk("R9 wr_sel", wr_sel, 0);
        @(negedge clk);
        ior = 0; iow = 0;
        rst = 0;
    endtask

    task automatic t_read();
        for (int a = 0; a < NR; a++) begin
            @(negedge clk);
            addr = AW'(a); ior = 1;
            #1;
            chk("R2 R5 rd_sel", rd_sel, 32'(1) << a);
            chk("R5 data_oe", data_oe, 1);
            chk("R6 ddis_n", ddis_n, 0);
            chk("R3 addr_o", addr_o, a);
            ior = 0;
            #1;
            chk("R5 release oe", data_oe, 0);
            chk("R6 release ddis", ddis_n, 1);
        end
        @(negedge clk);
        addr = 3'd5; ior_n = 0;
        #1;
        chk("R5 low strobe rd_sel", rd_sel, 32'h20);
        ior_n = 1;
        #1;
        chk("R5 low strobe release", rd_sel, 0);
        idle_bus();
    endtask

    task automatic t_cs();
        for (int c = 0; c < 7; c++) begin
            @(negedge clk);
            cs0 = c[0]; cs1 = c[1]; cs2_n = ~c[2];
            addr = 3'd1; ior = 1;
            #1;
            chk("R1 rd_sel deselected", rd_sel, 0);
            chk("R1 ddis deselected", ddis_n, 1);
            chk("R1 oe deselected", data_oe, 0);
            ior = 0; iow = 1;
            @(posedge clk); #1;
            chk("R1 wr_sel deselected", wr_sel, 0);
            @(negedge clk);
            iow = 0;
        end
        idle_bus();
    endtask

    task automatic t_write();
        @(negedge clk);
        addr = 3'd3; iow = 1;
        #1;
        chk("R7 no pulse before edge", wr_sel, 0);
        @(posedge clk); #1;
        chk("R7 pulse", wr_sel, 32'h08);
        @(posedge clk); #1;
        chk("R7 pulse ends", wr_sel, 0);
        @(posedge clk); #1;
        chk("R7 held strobe", wr_sel, 0);
        idle_bus();
        @(negedge clk);
        addr = 3'd6; iow_n = 0;
        @(posedge clk); #1;
        chk("R7 low strobe pulse", wr_sel, 32'h40);
        @(posedge clk); #1;
        chk("R7 low strobe ends", wr_sel, 0);
        idle_bus();
    endtask

    task automatic t_hold();
        @(negedge clk);
        addr = 3'd2;
        #1;
        chk("R3 transparent", addr_o, 2);
        @(negedge clk);
        as_n = 1;
        @(negedge clk);
        addr = 3'd7; cs0 = 0;
        #1;
        chk("R4 held addr", addr_o, 2);
        ior = 1;
        #1;
        chk("R4 held select read", rd_sel, 32'h04);
        ior = 0; iow = 1;
        @(posedge clk); #1;
        chk("R4 held write", wr_sel, 32'h04);
        idle_bus();
        @(negedge clk);
        cs2_n = 1; addr = 3'd0;
        @(negedge clk);
        as_n = 1;
        @(negedge clk);
        cs2_n = 0;
        ior = 1;
        #1;
        chk("R4 held deselect", rd_sel, 0);
        chk("R4 held deselect ddis", ddis_n, 1);
        idle_bus();
    endtask

    task automatic t_overlap();
        @(negedge clk);
        addr = 3'd1; ior = 1; iow = 1;
        #1;
        chk("R8 read wins", rd_sel, 32'h02);
        @(posedge clk); #1;
        chk("R8 no write during read", wr_sel, 0);
        @(negedge clk);
        ior = 0;
        @(posedge clk); #1;
        chk("R8 no late write", wr_sel, 0);
        @(posedge clk); #1;
        chk("R8 still none", wr_sel, 0);
        idle_bus();
    endtask

    initial begin
        t_reset();
        t_read();
        t_cs();
        t_write();
        t_hold();
        t_overlap();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog: actual timeout expected completion");
                end
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule